// File: doc/BRIEF.md
# Operand Addressing Mode Sequencer

This block sits between the opcode decoder and the execute stage of a small 8-bit accumulator processor. When a new instruction starts, it receives the addressing mode code, the address of the opcode, the index register and the branch condition. It then reads the operand bytes that follow the opcode over a byte-wide read port with a ready handshake. From those bytes it forms the operand's effective address, or passes the operand byte straight through in immediate mode. It also reports the instruction length and the program counter of the next instruction to execute.

The addressing modes are:
- immediate
- zero-page direct
- two-byte extended
- PC-relative branch
- indexed with no offset
- indexed with an unsigned 8-bit offset

A branch takes its target only when the condition flag is set. Otherwise execution falls through to the next instruction. The indexed 8-bit offset sum carries into bit 8, so it can reach up to 0x01FE. The block raises `done` for one cycle when its results are valid. The results stay on the outputs until the next instruction is accepted.

Top module: `opas_seq_top`

## Requirements
- R1: While reset is asserted, and after it is released, `done`, `busy` and `rd_req` are low until a start is accepted.
- R2: Mode code 0 (immediate): `imm_data` equals the byte read at opcode address + 1, `eff_addr` is 0x0000, `next_pc` is opcode address + 2, and in all other modes `imm_data` reads 0x00.
- R3: Mode code 1 (direct): `eff_addr` is {0x00, byte at opcode+1}, and `next_pc` is opcode + 2.
- R4: Mode code 2 (extended): the block reads opcode+1 (high byte) and then opcode+2 (low byte), both modulo 2^16. `eff_addr` is {high, low}, and `next_pc` is opcode + 3.
- R5: Mode code 3 (relative) with `cond_true` high: `next_pc` is (opcode + 2) plus the sign-extended offset byte, modulo 2^16, spanning -128..+127.
- R6: Mode code 3 with `cond_true` low: `next_pc` is opcode + 2. In both branch cases `eff_addr` shows the taken target.
- R7: Mode code 4 (indexed, no offset): no memory read is issued, `eff_addr` is {0x00, X}, `next_pc` is opcode + 1, and `done` rises one cycle after the start is accepted.
- R8: Mode code 5 (indexed, 8-bit offset): `eff_addr` is the 9-bit unsigned sum X + offset, zero-extended, at most 0x01FE, and `next_pc` is opcode + 2.
- R9: While `rd_req` is high and `rd_rdy` is low, the request and `rd_addr` hold. A byte is taken only in a cycle with `rd_req` and `rd_rdy` both high, at most one per cycle. The start-to-done latency is 1 + the sum over reads of (1 + wait cycles).
- R10: `done` is high for exactly one cycle per instruction. A `start` while `busy` is high is ignored.
- R11: Mode codes 6 and 7 behave as mode code 4.
- R12: `instr_len` reports the instruction length in bytes: 1 for codes 4, 6 and 7; 3 for code 2; 2 otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a new instruction (accepted when idle) |
| mode | input | 3 | Addressing mode code |
| pc_in | input | 16 | Address of the opcode byte |
| x_reg | input | 8 | Index register value |
| cond_true | input | 1 | Branch condition result |
| rd_req | output | 1 | Read request |
| rd_addr | output | 16 | Read address |
| rd_rdy | input | 1 | Read data valid this cycle |
| rd_data | input | 8 | Read data byte |
| busy | output | 1 | Instruction in progress |
| done | output | 1 | One-cycle strobe: results valid |
| eff_addr | output | 16 | Effective address (branch target in relative mode) |
| imm_data | output | 8 | Immediate operand |
| next_pc | output | 16 | Address of the next instruction to execute |
| instr_len | output | 2 | Instruction length in bytes |

## Verification
If the sequencer state goes wrong, the cycle count from start to `done` changes, the number of reads changes, or their order changes. Each of these shows at the ports within a few cycles of the start. A wrong captured byte, or a wrong carry or sign extension, shows as a wrong `eff_addr` or `next_pc` in the very cycle `done` is high. The vectors for those cases are chosen at the carry and sign boundaries: X and offset both 0xFF, offsets 0x7F and 0x80, and an address wrap at 0xFFFF.

// File: rtl/opas_pkg.sv
package opas_pkg;

  typedef enum logic [2:0] {
    AM_IMM  = 3'd0,
    AM_DIR  = 3'd1,
    AM_EXT  = 3'd2,
    AM_REL  = 3'd3,
    AM_IX0  = 3'd4,
    AM_IX8  = 3'd5,
    AM_RSV6 = 3'd6,
    AM_RSV7 = 3'd7
  } amode_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD1  = 2'd1,
    ST_RD2  = 2'd2,
    ST_FIN  = 2'd3
  } seq_st_e;

  // number of operand bytes read after the opcode
  function automatic logic [1:0] fetch_count(input amode_e m);
    case (m)
      AM_IMM, AM_DIR, AM_REL, AM_IX8: fetch_count = 2'd1;
      AM_EXT:                         fetch_count = 2'd2;
      default:                        fetch_count = 2'd0;
    endcase
  endfunction

  // total instruction length in bytes, opcode included
  function automatic logic [1:0] instr_bytes(input amode_e m);
    instr_bytes = fetch_count(m) + 2'd1;
  endfunction

endpackage

// File: rtl/opas_ctrl.sv
module opas_ctrl
  import opas_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   start,
  input  amode_e mode_new,
  input  amode_e mode_cur,
  input  logic   rd_rdy,
  output logic   load_en,
  output logic   b1_en,
  output logic   b2_en,
  output logic   rd_req,
  output logic   rd_sel,
  output logic   done,
  output logic   busy
);

  seq_st_e state_q;
  seq_st_e state_d;
  logic    st_en;

  // next-state logic
  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_IDLE: if (start) state_d = (fetch_count(mode_new) == 2'd0) ? ST_FIN : ST_RD1;
      ST_RD1:  if (rd_rdy) state_d = (fetch_count(mode_cur) == 2'd2) ? ST_RD2 : ST_FIN;
      ST_RD2:  if (rd_rdy) state_d = ST_FIN;
      ST_FIN:  state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  assign st_en = (state_d != state_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     state_q <= ST_IDLE;
    else if (st_en) state_q <= state_d;
  end

  assign load_en = (state_q == ST_IDLE) && start;
  assign rd_req  = (state_q == ST_RD1) || (state_q == ST_RD2);
  assign rd_sel  = (state_q == ST_RD2);
  assign b1_en   = (state_q == ST_RD1) && rd_rdy;
  assign b2_en   = (state_q == ST_RD2) && rd_rdy;
  assign done    = (state_q == ST_FIN);
  assign busy    = (state_q != ST_IDLE);

endmodule

// File: rtl/opas_capture.sv
module opas_capture
  import opas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8,
  parameter int NBYTES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [NBYTES-1:0] byte_en,
  input  amode_e            mode_i,
  input  logic [ADDR_W-1:0] pc_i,
  input  logic [DATA_W-1:0] x_i,
  input  logic              cond_i,
  input  logic [DATA_W-1:0] rd_data,
  output amode_e            mode_q,
  output logic [ADDR_W-1:0] pc_q,
  output logic [DATA_W-1:0] x_q,
  output logic              cond_q,
  output logic [DATA_W-1:0] opb_q [NBYTES]
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= AM_IMM;
      pc_q   <= '0;
      x_q    <= '0;
      cond_q <= 1'b0;
    end else if (load_en) begin
      mode_q <= mode_i;
      pc_q   <= pc_i;
      x_q    <= x_i;
      cond_q <= cond_i;
    end
  end

  // one register per operand byte; a new instruction clears them
  for (genvar g = 0; g < NBYTES; g++) begin : g_opb
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          opb_q[g] <= '0;
      else if (load_en)    opb_q[g] <= '0;
      else if (byte_en[g]) opb_q[g] <= rd_data;
    end
  end

endmodule

// File: rtl/opas_addr_calc.sv
module opas_addr_calc
  import opas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  amode_e            mode_q,
  input  logic [ADDR_W-1:0] pc_q,
  input  logic [DATA_W-1:0] x_q,
  input  logic              cond_q,
  input  logic [DATA_W-1:0] b1,
  input  logic [DATA_W-1:0] b2,
  input  logic              rd_sel,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] imm_data,
  output logic [ADDR_W-1:0] next_pc,
  output logic [1:0]        instr_len
);

  localparam int SUM_W = DATA_W + 1;
  localparam int PAD_W = ADDR_W - DATA_W;

  logic [ADDR_W-1:0] seq_pc;
  logic [ADDR_W-1:0] rel_tgt;
  logic [SUM_W-1:0]  ix_sum;

  assign instr_len = instr_bytes(mode_q);
  assign seq_pc    = pc_q + ADDR_W'(instr_len);
  assign rel_tgt   = seq_pc + {{PAD_W{b1[DATA_W-1]}}, b1};
  assign ix_sum    = {1'b0, x_q} + {1'b0, b1};
  assign rd_addr   = pc_q + ADDR_W'(1) + ADDR_W'(rd_sel);

  always_comb begin
    eff_addr = '0;
    imm_data = '0;
    next_pc  = seq_pc;
    case (mode_q)
      AM_IMM: imm_data = b1;
      AM_DIR: eff_addr = {{PAD_W{1'b0}}, b1};
      AM_EXT: eff_addr = {b1, b2};
      AM_REL: begin
        eff_addr = rel_tgt;
        if (cond_q) next_pc = rel_tgt;
      end
      AM_IX8: eff_addr = {{(ADDR_W-SUM_W){1'b0}}, ix_sum};
      default: eff_addr = {{PAD_W{1'b0}}, x_q};
    endcase
  end

endmodule

// File: rtl/opas_seq_top.sv
module opas_seq_top
  import opas_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [2:0]        mode,
  input  logic [ADDR_W-1:0] pc_in,
  input  logic [DATA_W-1:0] x_reg,
  input  logic              cond_true,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic              rd_rdy,
  input  logic [DATA_W-1:0] rd_data,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] eff_addr,
  output logic [DATA_W-1:0] imm_data,
  output logic [ADDR_W-1:0] next_pc,
  output logic [1:0]        instr_len
);

  localparam int NBYTES = 2;

  logic              rst_meta_n;
  logic              rst_sync_n;
  logic              load_en;
  logic              b1_en;
  logic              b2_en;
  logic              rd_sel;
  amode_e            mode_in;
  amode_e            cap_mode;
  logic [ADDR_W-1:0] cap_pc;
  logic [DATA_W-1:0] cap_x;
  logic              cap_cond;
  logic [DATA_W-1:0] cap_opb [NBYTES];

  // reset asserts at once, releases on the second clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_n <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_n <= 1'b1;
      rst_sync_n <= rst_meta_n;
    end
  end

  assign mode_in = amode_e'(mode);

  opas_ctrl u_ctrl (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .start    (start),
    .mode_new (mode_in),
    .mode_cur (cap_mode),
    .rd_rdy   (rd_rdy),
    .load_en  (load_en),
    .b1_en    (b1_en),
    .b2_en    (b2_en),
    .rd_req   (rd_req),
    .rd_sel   (rd_sel),
    .done     (done),
    .busy     (busy)
  );

  opas_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .NBYTES(NBYTES)) u_cap (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .load_en (load_en),
    .byte_en ({b2_en, b1_en}),
    .mode_i  (mode_in),
    .pc_i    (pc_in),
    .x_i     (x_reg),
    .cond_i  (cond_true),
    .rd_data (rd_data),
    .mode_q  (cap_mode),
    .pc_q    (cap_pc),
    .x_q     (cap_x),
    .cond_q  (cap_cond),
    .opb_q   (cap_opb)
  );

  opas_addr_calc #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_calc (
    .mode_q    (cap_mode),
    .pc_q      (cap_pc),
    .x_q       (cap_x),
    .cond_q    (cap_cond),
    .b1        (cap_opb[0]),
    .b2        (cap_opb[1]),
    .rd_sel    (rd_sel),
    .rd_addr   (rd_addr),
    .eff_addr  (eff_addr),
    .imm_data  (imm_data),
    .next_pc   (next_pc),
    .instr_len (instr_len)
  );

endmodule

// File: rtl/opas_seq_chk.sv
module opas_seq_chk
  import opas_pkg::*;
#(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              done,
  input logic              busy,
  input logic              rd_req,
  input logic              rd_rdy,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] eff_addr,
  input logic [ADDR_W-1:0] next_pc,
  input logic [1:0]        instr_len,
  input amode_e            cap_mode,
  input logic [ADDR_W-1:0] cap_pc,
  input logic              cap_cond
);

  assert_read_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && !rd_rdy) |=> (rd_req && $stable(rd_addr)));

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy);

  assert_direct_page_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_mode == AM_DIR) |-> (eff_addr[ADDR_W-1:8] == '0));

  assert_ix8_ceiling_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_mode == AM_IX8) |-> (eff_addr <= ADDR_W'(16'h01FE)));

  assert_no_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && (cap_mode == AM_IX0 || cap_mode == AM_RSV6 || cap_mode == AM_RSV7)) |-> !rd_req);

  assert_fallthrough_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_mode == AM_REL && !cap_cond) |-> (next_pc == cap_pc + ADDR_W'(2)));

  assert_ext_len_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (done && cap_mode == AM_EXT) |-> (instr_len == 2'd3));

endmodule

bind opas_seq_top opas_seq_chk #(.ADDR_W(ADDR_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_sync_n),
  .done      (done),
  .busy      (busy),
  .rd_req    (rd_req),
  .rd_rdy    (rd_rdy),
  .rd_addr   (rd_addr),
  .eff_addr  (eff_addr),
  .next_pc   (next_pc),
  .instr_len (instr_len),
  .cap_mode  (cap_mode),
  .cap_pc    (cap_pc),
  .cap_cond  (cap_cond)
);

// File: tb/test_opas_seq_top.sv
`timescale 1ns/1ps
module test_opas_seq_top;

  typedef struct packed {
    logic [2:0]  md;
    logic [15:0] pc;
    logic [7:0]  x;
    logic        c;
    logic [7:0]  b1;
    logic [7:0]  b2;
    logic [1:0]  st;
    logic [15:0] ea;
    logic [15:0] np;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{3'd0, 16'h0100, 8'h00, 1'b0, 8'hA7, 8'h00, 2'd0, 16'h0000, 16'h0102}, // R2
    '{3'd1, 16'h0200, 8'h00, 1'b0, 8'h80, 8'h00, 2'd1, 16'h0080, 16'h0202}, // R3
    '{3'd2, 16'h0300, 8'h00, 1'b0, 8'h12, 8'h34, 2'd2, 16'h1234, 16'h0303}, // R4
    '{3'd3, 16'h1000, 8'h00, 1'b1, 8'h7F, 8'h00, 2'd0, 16'h1081, 16'h1081}, // R5 +127
    '{3'd3, 16'h1000, 8'h00, 1'b1, 8'h80, 8'h00, 2'd0, 16'h0F82, 16'h0F82}, // R5 -128
    '{3'd3, 16'h1000, 8'h00, 1'b0, 8'h80, 8'h00, 2'd0, 16'h0F82, 16'h1002}, // R6
    '{3'd3, 16'hFFFE, 8'h00, 1'b1, 8'h05, 8'h00, 2'd0, 16'h0005, 16'h0005}, // R5 wrap
    '{3'd4, 16'h0400, 8'h3C, 1'b0, 8'h00, 8'h00, 2'd0, 16'h003C, 16'h0401}, // R7
    '{3'd5, 16'h0500, 8'hFF, 1'b0, 8'hFF, 8'h00, 2'd0, 16'h01FE, 16'h0502}, // R8 max
    '{3'd5, 16'h0600, 8'h10, 1'b0, 8'h20, 8'h00, 2'd1, 16'h0030, 16'h0602}, // R8
    '{3'd6, 16'h0700, 8'h55, 1'b1, 8'h00, 8'h00, 2'd0, 16'h0055, 16'h0701}, // R11
    '{3'd7, 16'hFFFF, 8'hAA, 1'b0, 8'h00, 8'h00, 2'd0, 16'h00AA, 16'h0000}, // R11
    '{3'd2, 16'hFFFE, 8'h00, 1'b0, 8'hC0, 8'hDE, 2'd0, 16'hC0DE, 16'h0001}, // R4 wrap
    '{3'd3, 16'h2000, 8'h00, 1'b1, 8'hFE, 8'h00, 2'd3, 16'h2000, 16'h2000}  // R5, R9
  };

  logic        clk;
  logic        rst_n;
  logic        start;
  logic [2:0]  mode;
  logic [15:0] pc_in;
  logic [7:0]  x_reg;
  logic        cond_true;
  logic        rd_req;
  logic [15:0] rd_addr;
  logic        rd_rdy;
  logic [7:0]  rd_data;
  logic        busy;
  logic        done;
  logic [15:0] eff_addr;
  logic [7:0]  imm_data;
  logic [15:0] next_pc;
  logic [1:0]  instr_len;

  logic [15:0] cur_pc = 16'h0;
  logic [7:0]  cur_b1 = 8'h0;
  logic [7:0]  cur_b2 = 8'h0;
  logic [1:0]  stall  = 2'd0;
  logic [1:0]  wcnt   = 2'd0;
  int          nrd    = 0;
  logic [15:0] rlog [2];
  int          n_chk  = 0;
  int          n_bad  = 0;

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  opas_seq_top i_opas_seq_top (
    .clk (clk), .rst_n (rst_n), .start (start), .mode (mode), .pc_in (pc_in),
    .x_reg (x_reg), .cond_true (cond_true), .rd_req (rd_req), .rd_addr (rd_addr),
    .rd_rdy (rd_rdy), .rd_data (rd_data), .busy (busy), .done (done),
    .eff_addr (eff_addr), .imm_data (imm_data), .next_pc (next_pc), .instr_len (instr_len)
  );

  // memory responder with a programmable number of wait cycles per read
  assign rd_rdy  = rd_req && (wcnt == 2'd0);
  assign rd_data = (rd_addr == cur_pc + 16'd1) ? cur_b1 :
                   (rd_addr == cur_pc + 16'd2) ? cur_b2 : 8'hEE;

  always_ff @(posedge clk) begin
    if (start && !busy) begin
      wcnt <= stall;
      nrd  <= 0;
    end else if (rd_req && rd_rdy) begin
      wcnt <= stall;
      if (nrd < 2) rlog[nrd] <= rd_addr;
      nrd <= nrd + 1;
    end else if (rd_req && wcnt != 2'd0) begin
      wcnt <= wcnt - 2'd1;
    end
  end

  task automatic chk(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic int nbytes(input logic [2:0] m);
    if (m == 3'd2) return 2;
    if (m >= 3'd4 && m != 3'd5) return 0;
    return 1;
  endfunction

  task automatic wait_done(output int lat);
    lat = 1;
    while (!done && lat < 100) begin
      @(negedge clk);
      lat++;
    end
    if (!done) chk("R10", "watchdog expired", 32'd0, 32'd1);
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    int lat;
    int nb;
    string rq;
    rq = (v.md == 3'd0) ? "R2" : (v.md == 3'd1) ? "R3" : (v.md == 3'd2) ? "R4" :
         (v.md == 3'd3) ? (v.c ? "R5" : "R6") : (v.md == 3'd5) ? "R8" :
         (v.md == 3'd4) ? "R7" : "R11";
    nb = nbytes(v.md);
    @(negedge clk);
    cur_pc = v.pc; cur_b1 = v.b1; cur_b2 = v.b2; stall = v.st;
    mode = v.md; pc_in = v.pc; x_reg = v.x; cond_true = v.c; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(lat);
    chk(rq, $sformatf("vec %0d eff_addr", idx), {16'h0, eff_addr}, {16'h0, v.ea});
    chk(rq, $sformatf("vec %0d next_pc", idx), {16'h0, next_pc}, {16'h0, v.np});
    chk("R2", $sformatf("vec %0d imm_data", idx), {24'h0, imm_data},
        {24'h0, (v.md == 3'd0) ? v.b1 : 8'h00});
    chk("R12", $sformatf("vec %0d instr_len", idx), {30'h0, instr_len}, 32'(nb + 1));
    chk("R9", $sformatf("vec %0d latency", idx), 32'(lat), 32'(1 + nb * (1 + int'(v.st))));
    chk("R9", $sformatf("vec %0d read count", idx), 32'(nrd), 32'(nb));
    if (nb >= 1) chk("R4", $sformatf("vec %0d first read addr", idx), {16'h0, rlog[0]}, {16'h0, v.pc + 16'd1});
    if (nb == 2) chk("R4", $sformatf("vec %0d second read addr", idx), {16'h0, rlog[1]}, {16'h0, v.pc + 16'd2});
    @(negedge clk);
    chk("R10", $sformatf("vec %0d done width", idx), {31'h0, done}, 32'd0);
  endtask

  initial begin
    int ndone;
    start = 1'b0; mode = 3'd0; pc_in = 16'h0; x_reg = 8'h0; cond_true = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1", "done in reset", {31'h0, done}, 32'd0);
    chk("R1", "busy in reset", {31'h0, busy}, 32'd0);
    chk("R1", "rd_req in reset", {31'h0, rd_req}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "busy after reset", {31'h0, busy}, 32'd0);
    chk("R1", "done after reset", {31'h0, done}, 32'd0);

    for (int i = 0; i < NV; i++) run_vec(VECS[i], i);

    // R10: a second start while busy is ignored
    @(negedge clk);
    cur_pc = 16'h3000; cur_b1 = 8'hAB; cur_b2 = 8'hCD; stall = 2'd3;
    mode = 3'd2; pc_in = 16'h3000; x_reg = 8'h00; cond_true = 1'b0; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    mode = 3'd4; pc_in = 16'h5000; x_reg = 8'h99; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ndone = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (done) begin
        ndone++;
        chk("R10", "eff_addr after ignored start", {16'h0, eff_addr}, 32'h0000ABCD);
        chk("R10", "next_pc after ignored start", {16'h0, next_pc}, 32'h00003003);
      end
    end
    chk("R10", "done count with ignored start", 32'(ndone), 32'd1);

    // R1: reset in the middle of a fetch
    @(negedge clk);
    stall = 2'd3; mode = 3'd2; pc_in = 16'h3000; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk("R1", "busy after mid reset", {31'h0, busy}, 32'd0);
    chk("R1", "rd_req after mid reset", {31'h0, rd_req}, 32'd0);
    chk("R1", "done after mid reset", {31'h0, done}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "idle after release", {31'h0, busy}, 32'd0);

    run_vec(VECS[8], 100);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule